// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It reads translation tables that sit in ordinary memory. A walk begins when `start_i` is seen while the block is idle. The block first fetches the entry for the current 4-bit context from a context table, whose location comes from a pointer-style base input. It then descends through up to three further tables, each indexed by a slice of the virtual address. Every table read is a single 32-bit word read through a request/response memory port.

Each fetched word carries a 2-bit type tag. The tag tells the walker whether to descend, to stop on a leaf, or to fault. A leaf can be found at the page level, or early at the first or second table level, where it maps a larger page. The leaf's 3-bit access code is checked against the access kind and the privilege mode. On success the walker reports the physical address and the cacheable flag. It also marks the leaf as referenced, and as modified on a write, by writing the word back. A walk that fails reports the level at which it stopped and the cause.

Top module: `ptw_walker`

## Requirements
- R1: The low two bits of every fetched word give its type: 0 is invalid, 1 points to a further table, and 2 or 3 is a leaf. Both leaf codes behave identically.
- R2: The walk reads the context entry at level 0, indexed by `ctx_i`. It then reads the first table (level 1) indexed by VA[31:24], the second (level 2) indexed by VA[23:18], and the page table (level 3) indexed by VA[17:12].
- R3: A table base is the pointer word (or `ctx_ptr_i` for the context table) with bits 1:0 cleared and shifted left by 4, giving a 36-bit address. An entry's address is that base plus four times its index.
- R4: A leaf holds its page number in bits 31:8. The physical address is that number shifted left by 12, with the low VA bits passed through in place of its low bits. The pass-through is VA[11:0] for a level-3 leaf, VA[17:0] for a level-2 leaf (256 KB) and VA[23:0] for a level-1 leaf (16 MB).
- R5: In user mode, access codes 0..7 grant {read}, {read,write}, {read,exec}, {read,write,exec}, {exec}, {read}, {} and {} respectively. `acc_i` is 0 for read, 1 for write and 2 for execute. An access the code does not grant ends with cause 2 (protection) at the leaf's level.
- R6: In supervisor mode, codes 0..7 grant {read}, {read,write}, {read,exec}, {read,write,exec}, {exec}, {read,write}, {read,exec} and {read,write,exec}. A denied access ends with cause 2.
- R7: On success the leaf is updated: bit 5 (referenced) is set, and bit 6 (modified) is also set on a write. The word is written back to the same address, in one write after the final read, only if it changed.
- R8: `cacheable_o` equals bit 7 of the successful leaf.
- R9: The walk ends with `fault_o`=1 and cause 1 (invalid), reporting the level of the word that ended it, when that word is invalid, is a leaf at level 0, or is a pointer at level 3. On any fault, `pa_o` and `cacheable_o` are 0.
- R10: `mem_req_o`, `mem_we_o` and `mem_addr_o` stay stable until `mem_rsp_i` is seen high at a clock edge.
- R11: After reset the block is idle with all outputs 0. `done_o` pulses for one cycle at the end of each walk and holds the results until the next walk. `start_i` and the request inputs are ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk when idle |
| va_i | input | 32 | Virtual address |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| user_i | input | 1 | 1 for user mode, 0 for supervisor |
| ctx_i | input | CTX_W | Current context |
| ctx_ptr_i | input | 32 | Context table base in pointer form |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| pa_o | output | 36 | Physical address |
| cacheable_o | output | 1 | Leaf allows caching |
| fault_o | output | 1 | Walk failed |
| fault_level_o | output | 2 | Level of the last word read |
| fault_cause_o | output | 2 | 0 none, 1 invalid, 2 protection |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 36 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rsp_i | input | 1 | Response, completes the request |
| mem_rdata_i | input | 32 | Read data, valid with the response |

## Verification
The bench builds the walker with its default index widths: a 4-bit context, an 8-bit first-level index and 6-bit second- and third-level indices. These match the address-slice boundaries and large-page sizes stated in the requirements. With these widths, every table level, both early-leaf page sizes and all eight access codes in both modes can be reached by random table construction. The memory model stalls responses at random, so held requests and back-to-back read/write sequences are exercised on each level.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PA_W     = 36;
  localparam int PG_SHIFT = 12;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2} acc_e;
  typedef enum logic [1:0] {FC_NONE = 2'd0, FC_INVALID = 2'd1, FC_PROT = 2'd2} fcause_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WB} walk_st_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [31:0]      ptr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [PA_W-1:0]  addr_o
);
  // base = (ptr & ~3) << 4, entry = base + 4*idx
  assign addr_o = {ptr_i[31:2], 6'b0} + PA_W'({idx_i, 2'b00});
endmodule

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk
  import ptw_pkg::*;
(
  input  logic [2:0] code_i,
  input  logic       user_i,
  input  acc_e       acc_i,
  output logic       ok_o
);
  logic [2:0] u_rwx, s_rwx, rwx;

  always_comb begin
    unique case (code_i)
      3'd0: begin u_rwx = 3'b100; s_rwx = 3'b100; end
      3'd1: begin u_rwx = 3'b110; s_rwx = 3'b110; end
      3'd2: begin u_rwx = 3'b101; s_rwx = 3'b101; end
      3'd3: begin u_rwx = 3'b111; s_rwx = 3'b111; end
      3'd4: begin u_rwx = 3'b001; s_rwx = 3'b001; end
      3'd5: begin u_rwx = 3'b100; s_rwx = 3'b110; end
      3'd6: begin u_rwx = 3'b000; s_rwx = 3'b101; end
      default: begin u_rwx = 3'b000; s_rwx = 3'b111; end
    endcase
    rwx = user_i ? u_rwx : s_rwx;
    unique case (acc_i)
      ACC_READ:  ok_o = rwx[2];
      ACC_WRITE: ok_o = rwx[1];
      ACC_EXEC:  ok_o = rwx[0];
      default:   ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptw_pte_upd.sv
module ptw_pte_upd (
  input  logic [31:0] entry_i,
  input  logic        write_i,
  output logic        is_ptr_o,
  output logic        is_leaf_o,
  output logic [31:0] entry_o,
  output logic        changed_o
);
  assign is_ptr_o  = (entry_i[1:0] == 2'd1);
  assign is_leaf_o = entry_i[1];
  assign entry_o   = entry_i | {25'b0, 1'b0, write_i, 1'b1, 5'b0};
  assign changed_o = (entry_o != entry_i);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W = 4,
  parameter int L1_W  = 8,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      va_i,
  input  logic [1:0]       acc_i,
  input  logic             user_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic [31:0]      ctx_ptr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [35:0]      pa_o,
  output logic             cacheable_o,
  output logic             fault_o,
  output logic [1:0]       fault_level_o,
  output logic [1:0]       fault_cause_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [35:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_rsp_i,
  input  logic [31:0]      mem_rdata_i
);
  localparam int OFF_W = 32 - L1_W - L2_W - L3_W;
  localparam int IDX_A = (CTX_W > L1_W) ? CTX_W : L1_W;
  localparam int IDX_B = (L2_W > L3_W) ? L2_W : L3_W;
  localparam int IDX_W = (IDX_A > IDX_B) ? IDX_A : IDX_B;
  localparam logic [1:0] LAST_LVL = 2'd3;

  walk_st_e         st_q;
  logic [1:0]       lvl_q;
  logic [31:0]      va_q;
  acc_e             acc_q;
  logic             user_q;
  logic [PA_W-1:0]  addr_q;
  logic [31:0]      wdata_q;
  logic             done_q, cach_q, fault_q;
  logic [PA_W-1:0]  pa_q;
  logic [1:0]       flvl_q;
  fcause_e          cause_q;

  logic [IDX_W-1:0] nidx;
  logic [PA_W-1:0]  ctx_addr, next_addr, keep_mask, pa_leaf;
  logic [5:0]       keep_bits;
  logic             is_ptr, is_leaf, changed, perm_ok, leaf_here;
  logic [31:0]      upd_entry;

  always_comb begin
    unique case (lvl_q)
      2'd0:    nidx = IDX_W'(va_q[31 -: L1_W]);
      2'd1:    nidx = IDX_W'(va_q[31-L1_W -: L2_W]);
      default: nidx = IDX_W'(va_q[OFF_W+L3_W-1 -: L3_W]);
    endcase
  end

  ptw_addr_gen #(.IDX_W(IDX_W)) u_ctx_addr (
    .ptr_i(ctx_ptr_i), .idx_i(IDX_W'(ctx_i)), .addr_o(ctx_addr)
  );
  ptw_addr_gen #(.IDX_W(IDX_W)) u_next_addr (
    .ptr_i(mem_rdata_i), .idx_i(nidx), .addr_o(next_addr)
  );

  ptw_pte_upd u_upd (
    .entry_i(mem_rdata_i), .write_i(acc_q == ACC_WRITE),
    .is_ptr_o(is_ptr), .is_leaf_o(is_leaf), .entry_o(upd_entry), .changed_o(changed)
  );

  ptw_perm_chk u_perm (
    .code_i(mem_rdata_i[4:2]), .user_i(user_q), .acc_i(acc_q), .ok_o(perm_ok)
  );

  // low VA bits kept in place for large pages
  always_comb begin
    unique case (lvl_q)
      2'd1:    keep_bits = 6'(L2_W + L3_W + OFF_W);
      2'd2:    keep_bits = 6'(L3_W + OFF_W);
      default: keep_bits = 6'(OFF_W);
    endcase
    keep_mask = (PA_W'(1) << keep_bits) - PA_W'(1);
    pa_leaf   = ({mem_rdata_i[31:8], {PG_SHIFT{1'b0}}} & ~keep_mask)
              | (PA_W'(va_q) & keep_mask);
  end

  assign leaf_here = is_leaf && (lvl_q != 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      va_q    <= '0;
      acc_q   <= ACC_READ;
      user_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      cach_q  <= 1'b0;
      fault_q <= 1'b0;
      pa_q    <= '0;
      flvl_q  <= '0;
      cause_q <= FC_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          va_q   <= va_i;
          acc_q  <= acc_e'(acc_i);
          user_q <= user_i;
          addr_q <= ctx_addr;
          lvl_q  <= '0;
          st_q   <= ST_RD;
        end
        ST_RD: if (mem_rsp_i) begin
          if (is_ptr && lvl_q != LAST_LVL) begin
            addr_q <= next_addr;
            lvl_q  <= lvl_q + 2'd1;
          end else begin
            flvl_q <= lvl_q;
            if (leaf_here && perm_ok) begin
              pa_q    <= pa_leaf;
              cach_q  <= mem_rdata_i[7];
              fault_q <= 1'b0;
              cause_q <= FC_NONE;
              if (changed) begin
                wdata_q <= upd_entry;
                st_q    <= ST_WB;
              end else begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end
            end else begin
              pa_q    <= '0;
              cach_q  <= 1'b0;
              fault_q <= 1'b1;
              cause_q <= leaf_here ? FC_PROT : FC_INVALID;
              st_q    <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        ST_WB: if (mem_rsp_i) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = done_q;
  assign pa_o          = pa_q;
  assign cacheable_o   = cach_q;
  assign fault_o       = fault_q;
  assign fault_level_o = flvl_q;
  assign fault_cause_o = cause_q;
  assign mem_req_o     = (st_q == ST_RD) || (st_q == ST_WB);
  assign mem_we_o      = (st_q == ST_WB);
  assign mem_addr_o    = addr_q;
  assign mem_wdata_o   = wdata_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int CTX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [31:0]      va_i,
  input logic [1:0]       acc_i,
  input logic             user_i,
  input logic [CTX_W-1:0] ctx_i,
  input logic [31:0]      ctx_ptr_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [35:0]      pa_o,
  input logic             cacheable_o,
  input logic             fault_o,
  input logic [1:0]       fault_level_o,
  input logic [1:0]       fault_cause_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [35:0]      mem_addr_o,
  input logic [31:0]      mem_wdata_o,
  input logic             mem_rsp_i,
  input logic [31:0]      mem_rdata_i
);
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rsp_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_wb_same_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> mem_addr_o == $past(mem_addr_o));

  assert_wb_referenced_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[5]);

  assert_fault_outputs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> fault_cause_o != 2'd0 && !cacheable_o && pa_o == 36'd0);

  assert_ok_level_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> fault_cause_o == 2'd0 && fault_level_o != 2'd0);

  assert_prot_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_cause_o == 2'd2 |-> fault_level_o != 2'd0);

  assert_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !mem_req_o);
endmodule

bind ptw_walker ptw_walker_chk #(.CTX_W(CTX_W)) u_chk (.*);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] va;
  logic [1:0]  acc;
  logic        user;
  logic [3:0]  ctx;
  logic [31:0] ctxptr;
  logic        busy, done, cach, fault;
  logic [35:0] pa;
  logic [1:0]  flvl, fcause;
  logic        mem_req, mem_we;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rsp = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [logic [35:0]];
  int          wcnt = 0;
  logic [31:0] wlast;
  logic [35:0] wadr;
  bit          stall_q = 0;
  logic [35:0] stall_addr;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  ptw_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .va_i(va), .acc_i(acc),
    .user_i(user), .ctx_i(ctx), .ctx_ptr_i(ctxptr), .busy_o(busy), .done_o(done),
    .pa_o(pa), .cacheable_o(cach), .fault_o(fault), .fault_level_o(flvl),
    .fault_cause_o(fcause), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rsp_i(mem_rsp),
    .mem_rdata_i(mem_rdata)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [35:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [35:0] tab(logic [31:0] p);
    return {p[31:2], 6'b0};
  endfunction

  function automatic logic [35:0] idx4(logic [31:0] v, int l);
    if (l == 0) return 36'(v[31:24]) * 4;
    if (l == 1) return 36'(v[23:18]) * 4;
    return 36'(v[17:12]) * 4;
  endfunction

  // rights per requirement tables: {r,w,x}
  function automatic bit allowed(logic [2:0] code, bit usr, logic [1:0] a);
    logic [2:0] r;
    if (usr) r = (code == 0 || code == 5) ? 3'b100 : (code == 1) ? 3'b110 :
                 (code == 2) ? 3'b101 : (code == 3) ? 3'b111 : (code == 4) ? 3'b001 : 3'b000;
    else     r = (code == 0) ? 3'b100 : (code == 1 || code == 5) ? 3'b110 :
                 (code == 2 || code == 6) ? 3'b101 : (code == 4) ? 3'b001 : 3'b111;
    return (a == 0) ? r[2] : (a == 1) ? r[1] : (a == 2) ? r[0] : 1'b0;
  endfunction

  // memory model with random stalls; R10 request hold check
  always @(negedge clk) begin
    automatic bit gave = 0;
    if (stall_q) begin
      chk("R10", "request held", {27'd0, mem_req, mem_addr}, {27'd0, 1'b1, stall_addr});
    end
    if (!mem_rsp && mem_req && ($urandom % 4 != 0)) begin
      gave = 1;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wcnt++;
        wlast = mem_wdata;
        wadr = mem_addr;
      end else begin
        mem_rdata <= rd(mem_addr);
      end
    end
    mem_rsp <= gave;
    stall_q = mem_req && !gave && !mem_rsp;
    stall_addr = mem_addr;
  end

  task automatic run_vec(int t0, int t1, int t2, int t3, logic [2:0] code, bit rb, bit mb,
                         bit cb, logic [31:0] v, logic [1:0] a, bit usr, logic [3:0] cx,
                         bit scramble);
    int t [4];
    logic [35:0] ad, leaf_ad;
    logic [31:0] e;
    bit e_fault, e_wr;
    logic [1:0] e_lvl, e_cause;
    logic [35:0] e_pa, msk;
    bit e_cach;
    logic [31:0] e_wd;
    int keep, to;
    string ftag;
    t[0] = t0; t[1] = t1; t[2] = t2; t[3] = t3;
    mem.delete();
    ctxptr = $urandom() & 32'h0FFF_FFFF;
    ad = tab(ctxptr) + 36'(cx) * 4;
    for (int l = 0; l < 4; l++) begin
      if (t[l] == 1) begin
        e = {4'(l + 1), 26'($urandom()), 2'b01};
        mem[ad] = e;
        if (l == 3) break;
        ad = tab(e) + idx4(v, l);
      end else if (t[l] == 0) begin
        mem[ad] = $urandom() & 32'hFFFF_FFFC;
        break;
      end else begin
        e = $urandom();
        mem[ad] = {e[31:8], cb, mb, rb, code, 2'(t[l])};
        break;
      end
    end
    // reference walk over the table image
    e_fault = 1; e_cause = 1; e_lvl = 0; e_pa = 0; e_cach = 0; e_wr = 0; e_wd = 0; leaf_ad = 0;
    ad = tab(ctxptr) + 36'(cx) * 4;
    for (int l = 0; l < 4; l++) begin
      e = rd(ad);
      e_lvl = 2'(l);
      if (e[1:0] == 2'd1 && l < 3) begin
        ad = tab(e) + idx4(v, l);
        continue;
      end
      if (e[1] && l > 0) begin
        if (!allowed(e[4:2], usr, a)) begin
          e_cause = 2;
        end else begin
          e_fault = 0; e_cause = 0;
          keep = (l == 1) ? 24 : (l == 2) ? 18 : 12;
          msk = (36'd1 << keep) - 1;
          e_pa = ({e[31:8], 12'h0} & ~msk) | ({4'h0, v} & msk);
          e_cach = e[7];
          e_wd = e | 32'h20 | ((a == 1) ? 32'h40 : 32'h0);
          e_wr = (e_wd != e);
          leaf_ad = ad;
        end
      end
      break;
    end
    // stimulus
    wcnt = 0;
    va = v; acc = a; user = usr; ctx = cx; start = 1'b1;
    @(negedge clk);
    if (!scramble) start = 1'b0;
    to = 0;
    while (!done && to < 200) begin
      if (scramble) begin
        va = $urandom(); acc = 2'($urandom()); user = ~user; ctx = 4'($urandom());
      end
      @(negedge clk);
      to++;
    end
    start = 1'b0;
    chk("R11", "done pulse", {63'd0, done}, 64'd1);
    ftag = (e_cause == 2) ? (usr ? "R5" : "R6") : "R1 R9";
    chk(ftag, "fault", {63'd0, fault}, {63'd0, e_fault});
    chk(ftag, "cause", {62'd0, fcause}, {62'd0, e_cause});
    chk("R2", "level", {62'd0, flvl}, {62'd0, e_lvl});
    chk("R3 R4", "pa", {28'd0, pa}, {28'd0, e_pa});
    chk("R8", "cacheable", {63'd0, cach}, {63'd0, e_cach});
    chk("R7", "write count", 64'(wcnt), e_wr ? 64'd1 : 64'd0);
    if (e_wr && wcnt == 1) begin
      chk("R7", "write data", {32'd0, wlast}, {32'd0, e_wd});
      chk("R7", "write addr", {28'd0, wadr}, {28'd0, leaf_ad});
    end
    @(negedge clk);
    chk("R11", "done single", {63'd0, done}, 64'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 0; va = 0; acc = 0; user = 0; ctx = 0; ctxptr = 0;
    repeat (3) @(negedge clk);
    chk("R11", "reset busy", {63'd0, busy}, 64'd0);
    chk("R11", "reset done", {63'd0, done}, 64'd0);
    chk("R11", "reset fault", {63'd0, fault}, 64'd0);
    chk("R11", "reset req", {63'd0, mem_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_vec(1,1,1,2, 3'd3, 1,0,1, 32'h1234_5678, 2'd0, 0, 4'd3, 0); // R7 no change on read
    run_vec(1,1,1,2, 3'd1, 1,1,0, 32'hFEDC_BA98, 2'd1, 1, 4'd15, 0); // R7 no change on write
    run_vec(1,1,1,2, 3'd6, 0,0,1, 32'h0000_1000, 2'd0, 1, 4'd0, 0); // R5 user none
    run_vec(1,1,1,2, 3'd7, 0,0,1, 32'hABCD_EF01, 2'd1, 0, 4'd7, 0); // R6 sup write + R,M
    run_vec(0,0,0,0, 3'd0, 0,0,0, 32'h5555_AAAA, 2'd0, 0, 4'd1, 0); // R9 level 0
    run_vec(2,0,0,0, 3'd3, 0,0,1, 32'h5555_AAAA, 2'd0, 0, 4'd2, 0); // R9 leaf at level 0
    run_vec(1,2,0,0, 3'd3, 0,0,1, 32'h89AB_CDEF, 2'd2, 0, 4'd4, 0); // R4 16 MB
    run_vec(1,1,3,0, 3'd2, 0,0,0, 32'h7654_3210, 2'd0, 1, 4'd5, 0); // R1 R4 type 3, 256 KB
    run_vec(1,1,1,1, 3'd0, 0,0,0, 32'h0F0F_0F0F, 2'd0, 0, 4'd6, 0); // R9 pointer at level 3
    run_vec(1,1,1,2, 3'd4, 0,0,1, 32'h1111_2222, 2'd2, 1, 4'd8, 0); // R5 exec-only
    run_vec(1,1,1,2, 3'd4, 0,0,1, 32'h1111_2222, 2'd0, 0, 4'd8, 0); // R6 exec-only read
    run_vec(1,1,1,2, 3'd5, 0,0,1, 32'h3333_4444, 2'd1, 1, 4'd9, 0); // R5 user write denied
    run_vec(1,1,1,2, 3'd5, 0,0,1, 32'h3333_4444, 2'd1, 0, 4'd9, 0); // R6 sup write allowed
    run_vec(1,1,1,2, 3'd3, 0,0,1, 32'hC0DE_F00D, 2'd1, 0, 4'd10, 1); // R11 inputs ignored while busy
    // random
    for (int i = 0; i < 400; i++) begin
      int r, tt [4];
      r = $urandom % 10; tt[0] = (r < 8) ? 1 : (r == 8) ? 0 : 2;
      for (int l = 1; l < 3; l++) begin
        r = $urandom % 10; tt[l] = (r < 7) ? 1 : (r == 7) ? 0 : (r == 8) ? 2 : 3;
      end
      r = $urandom % 10; tt[3] = (r == 0) ? 0 : (r == 1) ? 1 : 2 + (r % 2);
      run_vec(tt[0], tt[1], tt[2], tt[3], 3'($urandom()), 1'($urandom()), 1'($urandom()),
              1'($urandom()), $urandom(), 2'($urandom() % 3), 1'($urandom()),
              4'($urandom()), (i % 37) == 0);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule